// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register File

This block is the register file that software uses to steer an Ethernet DMA controller. It sits on a plain word-addressed register bus with separate read and write enables. It keeps the bus mode word, the receive and transmit ring base addresses and their current-descriptor pointers, the control word and the interrupt enable mask. The control bits, the pointers and the bus mode are driven out to the descriptor engines. The descriptor engines and all memory traffic live outside this block.

The descriptor engines report events through three single-cycle pulses: transmit frame done, receive frame done and receive buffer unavailable. Each pulse sets its cause bit and the matching summary bit in a write-one-to-clear status word. A single level interrupt line is raised while any status bit is set whose enable bit is also set. A write to either poll-demand address stores nothing. Instead it produces a one-cycle strobe toward the matching engine.

Word addresses: 0x00 bus mode, 0x01 transmit poll, 0x02 receive poll, 0x03 receive ring base, 0x04 transmit ring base, 0x05 status, 0x06 control, 0x07 interrupt enable, 0x08 transmit current pointer, 0x09 receive current pointer, 0x0A version.

Top module: `eth_dma_csr`

## Requirements
- R1: After reset every stored register reads zero, `irq` is low and both poll strobes are low.
- R2: A write to the status word (0x05) clears each status bit whose written bit is one and leaves every other bit as it was.
- R3: `tx_done` sets status bits 0 and 16, `rx_done` sets bits 6 and 16, and `rx_nobuf` sets bits 7 and 15. A bit set by a pulse in the same cycle as a clearing status write ends up set.
- R4: `irq` is high exactly while (status AND interrupt enable at 0x07) is non-zero. It follows a write or an engine pulse one clock later.
- R5: A write to the receive ring base (0x03) stores the value in both that register and the receive current pointer (0x09). A write to the transmit ring base (0x04) does the same for the transmit current pointer (0x08).
- R6: A write to the bus mode word (0x00) stores the value with bit 0 forced to zero.
- R7: A read of 0x0A returns 0x1012, and writes to that address change nothing.
- R8: A write to 0x01 gives a one-cycle `tx_poll` pulse in the cycle after the write, and a write to 0x02 gives a one-cycle `rx_poll` pulse. Both addresses read back zero.
- R9: `rx_enable` follows bit 1 of the control word (0x06) and `tx_start` follows bit 13.
- R10: Reads of addresses 0x0B and above return zero, and writes to them change no register.
- R11: Read data is registered. It is valid in the cycle after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request for `addr` |
| wr_en | input | 1 | Write request of `wr_data` to `addr` |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| tx_done | input | 1 | Transmit frame completed pulse |
| rx_done | input | 1 | Receive frame completed pulse |
| rx_nobuf | input | 1 | Receive buffer unavailable pulse |
| irq | output | 1 | Level interrupt |
| tx_poll | output | 1 | Transmit poll-demand strobe |
| rx_poll | output | 1 | Receive poll-demand strobe |
| rx_enable | output | 1 | Receive enable from control bit 1 |
| tx_start | output | 1 | Transmit start from control bit 13 |
| bus_mode | output | DATA_W | Stored bus mode word |
| tx_desc_ptr | output | DATA_W | Transmit current-descriptor pointer |
| rx_desc_ptr | output | DATA_W | Receive current-descriptor pointer |

## Verification
The status word is driven with each engine pulse alone, with stacked pulses, and with clearing masks that hit one bit, all bits, or bits that are not set. Together these separate a true write-one-to-clear from a plain overwrite or a full clear. One test puts a clearing write and a receive pulse in the same cycle, to check that the set has priority. The interrupt line is toggled once by changing only the enable mask and once by changing only the status word. This shows that it depends on both inputs. The base-pointer test first moves the current pointer on its own and then rewrites the base, so a design that does not reload the pointer gives a different value.

// File: rtl/eth_dma_csr_pkg.sv
package eth_dma_csr_pkg;

    // word addresses of the register window
    localparam int A_BUSMODE = 'h00;
    localparam int A_TXPOLL  = 'h01;
    localparam int A_RXPOLL  = 'h02;
    localparam int A_RXBASE  = 'h03;
    localparam int A_TXBASE  = 'h04;
    localparam int A_STATUS  = 'h05;
    localparam int A_CTRL    = 'h06;
    localparam int A_IEN     = 'h07;
    localparam int A_TXCUR   = 'h08;
    localparam int A_RXCUR   = 'h09;
    localparam int A_VERSION = 'h0A;

    localparam int VERSION_VAL = 'h1012;

    // status bit positions
    localparam int ST_TX_DONE  = 0;
    localparam int ST_RX_DONE  = 6;
    localparam int ST_RX_NOBUF = 7;
    localparam int ST_ABN_SUM  = 15;
    localparam int ST_NRM_SUM  = 16;

    // control bit positions
    localparam int CT_RX_EN    = 1;
    localparam int CT_TX_START = 13;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_BUSMODE,
        SEL_TXPOLL,
        SEL_RXPOLL,
        SEL_RXBASE,
        SEL_TXBASE,
        SEL_STATUS,
        SEL_CTRL,
        SEL_IEN,
        SEL_TXCUR,
        SEL_RXCUR,
        SEL_VERSION
    } reg_sel_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import eth_dma_csr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (addr)
            ADDR_W'(A_BUSMODE): sel = SEL_BUSMODE;
            ADDR_W'(A_TXPOLL):  sel = SEL_TXPOLL;
            ADDR_W'(A_RXPOLL):  sel = SEL_RXPOLL;
            ADDR_W'(A_RXBASE):  sel = SEL_RXBASE;
            ADDR_W'(A_TXBASE):  sel = SEL_TXBASE;
            ADDR_W'(A_STATUS):  sel = SEL_STATUS;
            ADDR_W'(A_CTRL):    sel = SEL_CTRL;
            ADDR_W'(A_IEN):     sel = SEL_IEN;
            ADDR_W'(A_TXCUR):   sel = SEL_TXCUR;
            ADDR_W'(A_RXCUR):   sel = SEL_RXCUR;
            ADDR_W'(A_VERSION): sel = SEL_VERSION;
            default:            sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/csr_status.sv
module csr_status #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic [DATA_W-1:0] set_mask,
    output logic [DATA_W-1:0] status_q
);

    logic [DATA_W-1:0] status_d;

    // set pulses override a clearing write on the same bit
    always_comb begin
        status_d = status_q;
        if (clr_en) begin
            status_d = status_d & ~clr_mask;
        end
        status_d = status_d | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    // R2: a clear with no coincident set leaves no written-one bit standing
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_mask == '0) |=> ((status_q & $past(clr_mask)) == '0));

    // R2: bits written zero keep their value
    a_r2_w1c_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_mask == '0) |=>
        ((status_q & ~$past(clr_mask)) == ($past(status_q) & ~$past(clr_mask))));

    // R3: every pulsed bit is set afterwards, clear or not
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((status_q & $past(set_mask)) == $past(set_mask)));

endmodule

// File: rtl/csr_rdmux.sv
module csr_rdmux
    import eth_dma_csr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] bus_mode,
    input  logic [DATA_W-1:0] rx_base,
    input  logic [DATA_W-1:0] tx_base,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [DATA_W-1:0] ien,
    input  logic [DATA_W-1:0] tx_cur,
    input  logic [DATA_W-1:0] rx_cur,
    output logic [DATA_W-1:0] rd_val
);

    always_comb begin
        unique case (sel)
            SEL_BUSMODE: rd_val = bus_mode;
            SEL_RXBASE:  rd_val = rx_base;
            SEL_TXBASE:  rd_val = tx_base;
            SEL_STATUS:  rd_val = status;
            SEL_CTRL:    rd_val = ctrl;
            SEL_IEN:     rd_val = ien;
            SEL_TXCUR:   rd_val = tx_cur;
            SEL_RXCUR:   rd_val = rx_cur;
            SEL_VERSION: rd_val = DATA_W'(VERSION_VAL);
            default:     rd_val = '0;   // poll strobes and unmapped
        endcase
    end

endmodule

// File: rtl/eth_dma_csr.sv
module eth_dma_csr
    import eth_dma_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic              rx_nobuf,
    output logic              irq,
    output logic              tx_poll,
    output logic              rx_poll,
    output logic              rx_enable,
    output logic              tx_start,
    output logic [DATA_W-1:0] bus_mode,
    output logic [DATA_W-1:0] tx_desc_ptr,
    output logic [DATA_W-1:0] rx_desc_ptr
);

    typedef struct packed {
        logic [DATA_W-1:0] bus_mode;
        logic [DATA_W-1:0] rx_base;
        logic [DATA_W-1:0] tx_base;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] ien;
        logic [DATA_W-1:0] tx_cur;
        logic [DATA_W-1:0] rx_cur;
        logic [DATA_W-1:0] rd_data;
        logic              tx_poll;
        logic              rx_poll;
    } csr_state_t;

    csr_state_t        st_d, st_q;
    reg_sel_e          sel;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] rd_val;
    logic              sts_clr;

    csr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    // engine pulses map onto cause and summary bits
    always_comb begin
        set_mask = '0;
        if (tx_done) begin
            set_mask[ST_TX_DONE] = 1'b1;
            set_mask[ST_NRM_SUM] = 1'b1;
        end
        if (rx_done) begin
            set_mask[ST_RX_DONE] = 1'b1;
            set_mask[ST_NRM_SUM] = 1'b1;
        end
        if (rx_nobuf) begin
            set_mask[ST_RX_NOBUF] = 1'b1;
            set_mask[ST_ABN_SUM]  = 1'b1;
        end
    end

    assign sts_clr = wr_en && (sel == SEL_STATUS);

    csr_status #(.DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (sts_clr),
        .clr_mask (wr_data),
        .set_mask (set_mask),
        .status_q (status_q)
    );

    csr_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .sel      (sel),
        .bus_mode (st_q.bus_mode),
        .rx_base  (st_q.rx_base),
        .tx_base  (st_q.tx_base),
        .status   (status_q),
        .ctrl     (st_q.ctrl),
        .ien      (st_q.ien),
        .tx_cur   (st_q.tx_cur),
        .rx_cur   (st_q.rx_cur),
        .rd_val   (rd_val)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tx_poll = 1'b0;
        st_d.rx_poll = 1'b0;
        if (rd_en) begin
            st_d.rd_data = rd_val;
        end
        if (wr_en) begin
            unique case (sel)
                SEL_BUSMODE: st_d.bus_mode = {wr_data[DATA_W-1:1], 1'b0};
                SEL_TXPOLL:  st_d.tx_poll  = 1'b1;
                SEL_RXPOLL:  st_d.rx_poll  = 1'b1;
                SEL_RXBASE: begin
                    st_d.rx_base = wr_data;
                    st_d.rx_cur  = wr_data;
                end
                SEL_TXBASE: begin
                    st_d.tx_base = wr_data;
                    st_d.tx_cur  = wr_data;
                end
                SEL_CTRL:    st_d.ctrl   = wr_data;
                SEL_IEN:     st_d.ien    = wr_data;
                SEL_TXCUR:   st_d.tx_cur = wr_data;
                SEL_RXCUR:   st_d.rx_cur = wr_data;
                default: ;   // status handled in u_status; version/unmapped ignored
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.rd_data;
    assign tx_poll     = st_q.tx_poll;
    assign rx_poll     = st_q.rx_poll;
    assign rx_enable   = st_q.ctrl[CT_RX_EN];
    assign tx_start    = st_q.ctrl[CT_TX_START];
    assign bus_mode    = st_q.bus_mode;
    assign tx_desc_ptr = st_q.tx_cur;
    assign rx_desc_ptr = st_q.rx_cur;
    assign irq         = |(status_q & st_q.ien);

    // R4: the line only changes after a register write or an engine pulse
    a_r4_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en || tx_done || rx_done || rx_nobuf));
    a_r4_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en));

    // R5: ring base write reloads the matching current pointer
    a_r5_rx_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RXBASE) |=> (rx_desc_ptr == $past(wr_data)));
    a_r5_tx_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_TXBASE) |=> (tx_desc_ptr == $past(wr_data)));

    // R6: bus mode bit 0 is dropped
    a_r6_busmode_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_BUSMODE) |=>
        (bus_mode == {$past(wr_data[DATA_W-1:1]), 1'b0}));

    // R7: version constant on read
    a_r7_version: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_VERSION) |=> (rd_data == DATA_W'(VERSION_VAL)));

    // R8: strobes only follow a poll-demand write
    a_r8_tx_poll_src: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll |-> $past(wr_en && sel == SEL_TXPOLL));
    a_r8_rx_poll_src: assert property (@(posedge clk) disable iff (!rst_n)
        rx_poll |-> $past(wr_en && sel == SEL_RXPOLL));

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rd_data == '0));

    // R11: read data holds without a read
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/eth_dma_csr_tb_top.sv
`timescale 1ns/1ps
module eth_dma_csr_tb_top;

    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_en, wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          tx_done, rx_done, rx_nobuf;
    logic          irq, tx_poll, rx_poll, rx_enable, tx_start;
    logic [DW-1:0] bus_mode, tx_desc_ptr, rx_desc_ptr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    eth_dma_csr #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .tx_done(tx_done), .rx_done(rx_done), .rx_nobuf(rx_nobuf),
        .irq(irq), .tx_poll(tx_poll), .rx_poll(rx_poll),
        .rx_enable(rx_enable), .tx_start(tx_start), .bus_mode(bus_mode),
        .tx_desc_ptr(tx_desc_ptr), .rx_desc_ptr(rx_desc_ptr)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input logic t, input logic r, input logic n);
        @(negedge clk);
        tx_done = t; rx_done = r; rx_nobuf = n;
        @(negedge clk);
        tx_done = 1'b0; rx_done = 1'b0; rx_nobuf = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        for (int a = 0; a < 10; a++) begin
            bus_read(AW'(a), v);
            check("R1 reset read", v, '0);
        end
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 polls", {30'b0, tx_poll, rx_poll}, 0);
    endtask

    task automatic t_version();
        logic [DW-1:0] v;
        bus_read(6'h0A, v);
        check("R7 version", v, 32'h1012);
        bus_write(6'h0A, 32'hFFFF_0000);
        bus_read(6'h0A, v);
        check("R7 version after write", v, 32'h1012);
        // R11: value holds with no further read
        @(negedge clk);
        check("R11 rd hold", rd_data, 32'h1012);
    endtask

    task automatic t_busmode();
        logic [DW-1:0] v;
        bus_write(6'h00, 32'hFFFF_FFFF);
        bus_read(6'h00, v);
        check("R6 bus mode", v, 32'hFFFF_FFFE);
        check("R6 bus mode port", bus_mode, 32'hFFFF_FFFE);
    endtask

    task automatic t_base();
        logic [DW-1:0] v;
        bus_write(6'h03, 32'h0000_1000);
        bus_read(6'h09, v);
        check("R5 rx cur", v, 32'h1000);
        bus_write(6'h09, 32'h0000_2000);
        check("R5 rx cur moved", rx_desc_ptr, 32'h2000);
        bus_write(6'h03, 32'h0000_3000);
        check("R5 rx cur reload", rx_desc_ptr, 32'h3000);
        bus_read(6'h03, v);
        check("R5 rx base", v, 32'h3000);
        bus_write(6'h08, 32'h0000_0500);
        bus_write(6'h04, 32'h0000_4000);
        check("R5 tx cur reload", tx_desc_ptr, 32'h4000);
        bus_read(6'h04, v);
        check("R5 tx base", v, 32'h4000);
    endtask

    task automatic t_ctrl();
        bus_write(6'h06, 32'h0000_2002);
        check("R9 rx enable", {31'b0, rx_enable}, 1);
        check("R9 tx start", {31'b0, tx_start}, 1);
        bus_write(6'h06, 32'h0000_0002);
        check("R9 tx start off", {31'b0, tx_start}, 0);
        check("R9 rx enable kept", {31'b0, rx_enable}, 1);
    endtask

    task automatic t_poll();
        logic [DW-1:0] v;
        bus_write(6'h01, 32'h1);
        check("R8 tx poll high", {31'b0, tx_poll}, 1);
        check("R8 rx poll quiet", {31'b0, rx_poll}, 0);
        @(negedge clk);
        check("R8 tx poll one cycle", {31'b0, tx_poll}, 0);
        bus_write(6'h02, 32'h1);
        check("R8 rx poll high", {31'b0, rx_poll}, 1);
        @(negedge clk);
        check("R8 rx poll one cycle", {31'b0, rx_poll}, 0);
        bus_read(6'h01, v);
        check("R8 tx poll reads zero", v, 0);
    endtask

    task automatic t_status();
        logic [DW-1:0] v;
        pulse(1, 0, 0);
        bus_read(6'h05, v);
        check("R3 tx done bits", v, 32'h0001_0001);
        pulse(0, 0, 1);
        bus_read(6'h05, v);
        check("R3 nobuf bits", v, 32'h0001_8081);
        bus_write(6'h05, 32'h0000_0001);
        bus_read(6'h05, v);
        check("R2 single clear", v, 32'h0001_8080);
        bus_write(6'h05, 32'h0000_0040);
        bus_read(6'h05, v);
        check("R2 clear unset bit", v, 32'h0001_8080);
        bus_write(6'h05, 32'hFFFF_FFFF);
        bus_read(6'h05, v);
        check("R2 clear all", v, 0);
    endtask

    task automatic t_collide();
        logic [DW-1:0] v;
        pulse(1, 0, 0);
        @(negedge clk);
        wr_en = 1'b1; addr = 6'h05; wr_data = 32'h0001_0041; rx_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rx_done = 1'b0;
        bus_read(6'h05, v);
        check("R3 set beats clear", v, 32'h0001_0040);
        bus_write(6'h05, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        bus_write(6'h07, 32'h0000_0040);
        check("R4 irq idle", {31'b0, irq}, 0);
        pulse(0, 1, 0);
        check("R4 irq on event", {31'b0, irq}, 1);
        bus_write(6'h07, 32'h0000_0000);
        check("R4 irq masked", {31'b0, irq}, 0);
        bus_write(6'h07, 32'h0000_0040);
        check("R4 irq unmasked", {31'b0, irq}, 1);
        bus_write(6'h05, 32'h0000_0040);
        check("R4 irq cleared", {31'b0, irq}, 0);
        pulse(1, 0, 0);
        check("R4 irq unenabled cause", {31'b0, irq}, 0);
        bus_write(6'h05, 32'hFFFF_FFFF);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] v;
        bus_write(6'h3F, 32'hDEAD_BEEF);
        bus_write(6'h0B, 32'hDEAD_BEEF);
        bus_read(6'h3F, v);
        check("R10 unmapped read", v, 0);
        bus_read(6'h0B, v);
        check("R10 unmapped read 0B", v, 0);
        bus_read(6'h07, v);
        check("R10 ien untouched", v, 32'h40);
        bus_read(6'h06, v);
        check("R10 ctrl untouched", v, 32'h2);
    endtask

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
        tx_done = 1'b0; rx_done = 1'b0; rx_nobuf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_version();
        t_busmode();
        t_base();
        t_ctrl();
        t_poll();
        t_status();
        t_collide();
        t_irq();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule